// File: doc/BRIEF.md
# Recirculating Video Line Delay Memory

This block delays a pixel stream by exactly one video line. Each pixel word is 12 bits wide: an 8-bit luma sample plus a 4-bit slice of multiplexed chroma. The store acts as a shift register on the pixel clock. Each accepted word pushes the oldest stored word out to the output. A line starts when the line-enable strobe rises. Words are accepted only while that strobe is high and the line has not yet filled the store. When a line carries more words than the store can hold, shifting stops and both the stored line and the output freeze until the next line start.

A recirculate control is sampled at each line start. In recirculate mode, every word leaving the store is written straight back in and the pixel input is ignored, so the same stored line is presented again on every later line. The stream interface has no back-pressure: the block never stalls its source. The line-enable strobe says which cycles carry pixels, and a word offered while the line is full is dropped.

Top module: `line_delay_mem`

## Requirements
- R1: The pixel word is packed as luma in bits 11:4 and chroma in bits 3:0. Both fields pass through the store unchanged and stay in those positions.
- R2: On every accepted shift, `pix_out` takes the word that was accepted DEPTH accepted shifts earlier. It changes on no other cycle.
- R3: A cycle with `line_en` high after a cycle with it low is a line start. In that cycle the word count restarts and the word is accepted, so the count is 1 after that edge.
- R4: Once DEPTH words have been accepted in the current line, further words in that line are ignored. The count stays at DEPTH, `pix_out` holds, and the stored contents are unchanged, which later lines expose.
- R5: While `line_en` is low, no word is accepted and `pix_out` holds its value.
- R6: `recirc` is sampled at each line start and applies to the whole line. In recirculate mode, each word leaving the store is written back in place of `pix_in`, so the stored line repeats on later lines.
- R7: Synchronous reset clears the word count, the latched mode (to normal) and `pix_out` (to 0). Stored words are undefined until DEPTH words have been accepted.
- R8: The delay counts accepted shifts, not lines. A run of lines shorter than DEPTH still yields each word exactly DEPTH accepted shifts after it entered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_in | input | 12 | Incoming pixel word {luma[7:0], chroma[3:0]} |
| line_en | input | 1 | Line-enable strobe; its rising edge starts a line |
| recirc | input | 1 | Recirculate request, sampled at line start |
| pix_out | output | 12 | Pixel word delayed by one line |

## Verification
Two functions can act on the same clock edge: releasing the hold of a saturated line when a new line starts, and switching between normal and recirculate mode. The bench provokes this by driving a line longer than the store and dropping `line_en` for a single cycle. It then raises `line_en` again with `recirc` flipped on that same edge. A sweep over every line length from 1 to DEPTH+3, alternating modes, repeats the pattern. Each output word is judged against a ring model computed in the bench. The model has the edge accept its word, restart the count and adopt the new mode all at once.

// File: rtl/lmem_pkg.sv
package lmem_pkg;
  localparam int LUMA_W   = 8;
  localparam int CHROMA_W = 4;
  localparam int PIX_W    = LUMA_W + CHROMA_W;

  typedef struct packed {
    logic [LUMA_W-1:0]   luma;
    logic [CHROMA_W-1:0] chroma;
  } pix_t;
endpackage

// File: rtl/lmem_ctrl.sv
module lmem_ctrl #(
  parameter int DEPTH = 852,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_en,
  input  logic          recirc,
  output logic          line_rise,
  output logic          shift_en,
  output logic          recirc_now,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] LIMIT = CW'(DEPTH);

  logic          en_q;
  logic          mode_q;
  logic [CW-1:0] cnt_eff;

  always_comb begin
    line_rise  = line_en & ~en_q;
    cnt_eff    = line_rise ? '0 : cnt;
    shift_en   = line_en && (cnt_eff < LIMIT);
    recirc_now = line_rise ? recirc : mode_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      mode_q <= 1'b0;
      cnt    <= '0;
    end else begin
      en_q <= line_en;
      if (line_rise) mode_q <= recirc;
      if (shift_en)  cnt    <= cnt_eff + CW'(1);
    end
  end
endmodule

// File: rtl/lmem_store.sv
module lmem_store #(
  parameter int DEPTH = 852,
  parameter int W     = lmem_pkg::PIX_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         recirc_now,
  input  logic [W-1:0] pix_in,
  output logic [W-1:0] pix_out
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  ring [DEPTH];
  logic [PW-1:0] ptr;
  logic [W-1:0]  oldest;
  logic [W-1:0]  wr_word;

  always_comb begin
    oldest  = ring[ptr];
    wr_word = recirc_now ? oldest : pix_in;
  end

  always_ff @(posedge clk) begin
    if (shift_en) ring[ptr] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr     <= '0;
      pix_out <= '0;
    end else if (shift_en) begin
      pix_out <= oldest;
      ptr     <= (ptr == LAST) ? '0 : ptr + PW'(1);
    end
  end
endmodule

// File: rtl/line_delay_mem.sv
module line_delay_mem #(
  parameter int DEPTH = 852
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [lmem_pkg::PIX_W-1:0] pix_in,
  input  logic                       line_en,
  input  logic                       recirc,
  output logic [lmem_pkg::PIX_W-1:0] pix_out
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          line_rise;
  logic          shift_en;
  logic          recirc_now;
  logic [CW-1:0] cnt;

  lmem_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .line_en(line_en), .recirc(recirc),
    .line_rise(line_rise), .shift_en(shift_en),
    .recirc_now(recirc_now), .cnt(cnt)
  );

  lmem_store #(.DEPTH(DEPTH), .W(lmem_pkg::PIX_W)) u_store (
    .clk(clk), .rst(rst), .shift_en(shift_en), .recirc_now(recirc_now),
    .pix_in(pix_in), .pix_out(pix_out)
  );
endmodule

// File: rtl/lmem_chk.sv
module lmem_chk #(
  parameter int DEPTH = 852,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       line_en,
  input logic [lmem_pkg::PIX_W-1:0] pix_out,
  input logic                       line_rise,
  input logic                       shift_en,
  input logic [CW-1:0]              cnt
);
  localparam logic [CW-1:0] LIMIT = CW'(DEPTH);

  // R3
  line_start_chk: assert property (@(posedge clk) disable iff (rst)
    line_rise |=> cnt == CW'(1));

  // R4
  hold_full_chk: assert property (@(posedge clk) disable iff (rst)
    (line_en && !line_rise && cnt == LIMIT) |=> $stable(pix_out));

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIMIT);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !line_en |=> $stable(pix_out));

  // R5
  no_shift_idle_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |-> line_en);

  // R7
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (cnt == '0 && pix_out == '0));
endmodule

bind line_delay_mem lmem_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .line_en(line_en), .pix_out(pix_out),
  .line_rise(line_rise), .shift_en(shift_en), .cnt(cnt)
);

// File: tb/line_delay_mem_tb.sv
module line_delay_mem_tb;
  localparam int D = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] pix_in = '0;
  logic        line_en = 1'b0;
  logic        recirc = 1'b0;
  logic [11:0] pix_out;

  int checks = 0;
  int fails  = 0;

  logic [11:0] m_ring [D];
  bit          m_vld  [D];
  int          m_ptr, m_cnt;
  bit          m_prev, m_mode;
  logic [11:0] m_out;
  bit          m_known;
  int          seed_v = 7;

  always #2 clk = ~clk;

  line_delay_mem #(.DEPTH(D)) u_dut (
    .clk(clk), .rst(rst), .pix_in(pix_in), .line_en(line_en),
    .recirc(recirc), .pix_out(pix_out)
  );

  task automatic report_summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    report_summary();
    $finish;
  end

  task automatic check(string req, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one pixel-clock cycle: drive, advance model, check after the edge
  task automatic step(bit en, bit rc, logic [11:0] d, string req);
    bit rise, md;
    int eff;
    line_en = en; recirc = rc; pix_in = d;
    rise = en && !m_prev;
    eff  = rise ? 0 : m_cnt;
    md   = rise ? rc : m_mode;
    if (en && eff < D) begin
      m_out   = m_ring[m_ptr];
      m_known = m_vld[m_ptr];
      if (!md) begin m_ring[m_ptr] = d; m_vld[m_ptr] = 1'b1; end
      m_ptr = (m_ptr + 1) % D;
      m_cnt = eff + 1;
    end
    if (rise) m_mode = rc;
    m_prev = en;
    @(posedge clk); #1;
    if (m_known) begin
      check(req, pix_out, m_out);
      if (req == "R1") begin
        check("R1 luma", {4'h0, pix_out[11:4]}, {4'h0, m_out[11:4]});
        check("R1 chroma", {8'h00, pix_out[3:0]}, {8'h00, m_out[3:0]});
      end
    end
  endtask

  function automatic logic [11:0] nextword();
    seed_v = (seed_v * 1103 + 2731) % 4096;
    return 12'(seed_v);
  endfunction

  task automatic run_line(int len, bit rc, string req);
    for (int i = 0; i < len; i++) step(1'b1, rc, nextword(), req);
  endtask

  task automatic idle(int n, string req);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, nextword(), req);
  endtask

  initial begin
    for (int i = 0; i < D; i++) m_vld[i] = 1'b0;
    m_ptr = 0; m_cnt = 0; m_prev = 0; m_mode = 0; m_out = '0; m_known = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R7: reset state at the output
    check("R7", pix_out, 12'h000);
    rst = 1'b0;

    // fill one line, then R1/R2: next line outputs the previous one
    run_line(D, 1'b0, "R2");
    idle(3, "R5");
    run_line(D, 1'b0, "R1");
    idle(2, "R5");
    // R4: overlong line freezes output and contents
    run_line(D + 8, 1'b0, "R4");
    idle(1, "R5");
    run_line(D, 1'b0, "R4");
    // R6: recirculated lines repeat the stored line
    idle(2, "R5");
    for (int k = 0; k < 3; k++) begin
      run_line(D, 1'b1, "R6");
      idle(1, "R6");
    end
    // R8: short lines keep an exact shift-count delay
    for (int k = 0; k < 9; k++) begin
      run_line(5, 1'b0, "R8");
      idle(1, "R8");
    end
    // R3/R6: restart right after a held line with the mode flipped
    run_line(D + 4, 1'b0, "R4");
    idle(1, "R3");
    run_line(D + 2, 1'b1, "R3");
    idle(1, "R3");
    run_line(D, 1'b0, "R6");
    // sweep of line lengths, alternating modes, single-cycle gaps
    for (int len = 1; len <= D + 3; len++) begin
      run_line(len, len % 2 == 0, "R3");
      idle(1 + len % 3, "R5");
    end
    run_line(D, 1'b0, "R8");
    report_summary();
    $finish;
  end
endmodule